// File: doc/BRIEF.md
# Event Fragment Frame Checker

This block taps a 64-bit point-to-point link that moves one word per clock under valid/ready flow control. It checks that every event fragment on the link is well formed as the words go by. A control flag travels with each word. A flagged word is either the fragment's opening header or its closing trailer, and unflagged words are payload. The checker tracks where each fragment begins and ends. It counts the words it receives and runs a CRC over the whole fragment. At the trailer it compares the count with the trailer's length field and compares the CRC with the trailer's CRC field.

For every fragment, and for every malformed piece of traffic, the checker produces a one-cycle status pulse. The pulse carries the identification fields taken from the header, the number of words received, and three separate error flags: CRC, length and framing. The checker never back-pressures the link. It only observes words that actually transfer, and it recovers by itself on the next header after any framing fault.

Top module: `frame_checker`

## Requirements
- R1: After reset the checker is hunting for a header, and `st_valid` stays low until a word is accepted.
- R2: An accepted word with `in_ctrl`=1 and `in_data[63:60]`=4'h5 opens a fragment. The status pulse for that fragment reports event type from bits [59:56], trigger number from [55:32], bunch-crossing number from [31:20] and source id from [19:8].
- R3: An accepted control word with `in_data[63:60]`=4'hA closes an open fragment. In the next cycle `st_valid` is high for exactly one cycle, with `st_frm_err`=0.
- R4: `st_len` is the number of accepted words in the fragment, header and trailer included. `st_len_err` is 1 when this count differs from trailer bits [55:32].
- R5: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. Each 64-bit word is shifted in MSB first (bit 63 first), across header, payload and trailer, with trailer bits [31:16] taken as zero. `st_crc_err` is 1 when the result differs from trailer bits [31:16].
- R6: A word transfers only when `in_valid` and `in_ready` are both high. Words offered without a transfer have no effect, and accepted payload words produce no status.
- R7: An accepted word other than a header while no fragment is open produces a status pulse with `st_frm_err`=1, `st_len`=0, all header fields 0, and CRC and length flags 0.
- R8: A header accepted inside an open fragment produces a status pulse for the aborted fragment. That pulse has `st_frm_err`=1, the old header fields, `st_len` equal to the words received so far, and CRC and length flags 0. The new header then opens a fresh fragment.
- R9: A control word inside a fragment whose marker is neither 4'h5 nor 4'hA produces a status pulse with `st_frm_err`=1 and `st_len` equal to the words before it, and the checker returns to hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Link source has a word |
| in_ready | input | 1 | Link sink takes the word |
| in_ctrl | input | 1 | Word is a header or trailer |
| in_data | input | 64 | Link word |
| st_valid | output | 1 | One-cycle status pulse |
| st_evt_type | output | 4 | Event type from header |
| st_trig | output | 24 | Trigger number from header |
| st_bx | output | 12 | Bunch-crossing number from header |
| st_src | output | 12 | Source identifier from header |
| st_len | output | 24 | Words received, saturating |
| st_crc_err | output | 1 | CRC mismatch |
| st_len_err | output | 1 | Length field mismatch |
| st_frm_err | output | 1 | Framing fault |

## Verification
The hardest situations to reach from the ports are a stalled transfer and a lost fragment. In a stalled transfer, a word that looks like a trailer is held on the bus with `in_ready` low. In a lost fragment, a second header or an unknown marker arrives before the trailer, and the checker must both report the abort and re-lock. The stimulus puts a fake trailer with ready deasserted in front of every payload word in the stalled vectors. It then runs directed sequences that cut fragments short, and it follows each cut with more traffic to show where the checker resumed. Expected CRCs are recomputed byte by byte in the bench.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int WORD_W = 64;
  localparam int CRC_W = 16;
  localparam logic [3:0] MARK_OPEN = 4'h5;
  localparam logic [3:0] MARK_CLOSE = 4'hA;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef struct packed {
    logic [3:0] evt_type;
    logic [23:0] trig;
    logic [11:0] bx;
    logic [11:0] src;
  } hdr_t;

  // Shift a whole word through the CRC register, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] c,
                                                input logic [WORD_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction

  function automatic hdr_t hdr_fields(input logic [WORD_W-1:0] w);
    hdr_t h;
    h.evt_type = w[59:56];
    h.trig = w[55:32];
    h.bx = w[31:20];
    h.src = w[19:8];
    return h;
  endfunction
endpackage

// File: rtl/fc_crc_acc.sv
module fc_crc_acc
  import fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [WORD_W-1:0] din,
  output logic [CRC_W-1:0]  crc_nxt
);
  logic [CRC_W-1:0] crc_q;

  assign crc_nxt = crc_word(load ? CRC_SEED : crc_q, din);

  always_ff @(posedge clk) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else if (load || step) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/fc_word_cnt.sv
module fc_word_cnt #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign cnt_nxt = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= CNT_W'(1);
    else if (inc) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/frame_checker.sv
module frame_checker
  import fc_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_ready,
  input  logic             in_ctrl,
  input  logic [63:0]      in_data,
  output logic             st_valid,
  output logic [3:0]       st_evt_type,
  output logic [23:0]      st_trig,
  output logic [11:0]      st_bx,
  output logic [11:0]      st_src,
  output logic [LEN_W-1:0] st_len,
  output logic             st_crc_err,
  output logic             st_len_err,
  output logic             st_frm_err
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [WORD_W-1:0] CRC_FIELD_MASK = {{(WORD_W-32){1'b0}}, 16'hFFFF, 16'h0000};

  function automatic logic [LEN_W-1:0] sat_len(input logic [CNT_W-1:0] c);
    return c[CNT_W-1] ? {LEN_W{1'b1}} : c[LEN_W-1:0];
  endfunction

  // Named internal events
  logic beat, is_open, is_close;
  logic hdr_beat, pay_beat, trl_beat, abort_beat, bad_beat, stray_beat;
  logic in_frag;
  hdr_t hdr_q;
  logic [CRC_W-1:0] crc_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [WORD_W-1:0] crc_din;
  logic crc_ok, len_ok;

  assign beat = in_valid && in_ready;
  assign is_open = in_ctrl && (in_data[63:60] == MARK_OPEN);
  assign is_close = in_ctrl && (in_data[63:60] == MARK_CLOSE);
  assign hdr_beat = beat && is_open;
  assign pay_beat = beat && !in_ctrl && in_frag;
  assign trl_beat = beat && is_close && in_frag;
  assign abort_beat = hdr_beat && in_frag;
  assign bad_beat = beat && in_ctrl && in_frag && !is_open && !is_close;
  assign stray_beat = beat && !in_frag && !is_open;

  assign crc_din = trl_beat ? (in_data & ~CRC_FIELD_MASK) : in_data;

  fc_crc_acc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (hdr_beat),
    .step    (pay_beat),
    .din     (crc_din),
    .crc_nxt (crc_nxt)
  );

  fc_word_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (hdr_beat),
    .inc     (pay_beat),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  assign crc_ok = (crc_nxt == in_data[31:16]);
  assign len_ok = (cnt_nxt == CNT_W'(in_data[55:32]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frag <= 1'b0;
      hdr_q <= '0;
    end else begin
      if (hdr_beat) begin
        in_frag <= 1'b1;
        hdr_q <= hdr_fields(in_data);
      end else if (trl_beat || bad_beat) begin
        in_frag <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      {st_evt_type, st_trig, st_bx, st_src} <= '0;
      st_len <= '0;
      st_crc_err <= 1'b0;
      st_len_err <= 1'b0;
      st_frm_err <= 1'b0;
    end else begin
      st_valid <= trl_beat || abort_beat || bad_beat || stray_beat;
      st_crc_err <= trl_beat && !crc_ok;
      st_len_err <= trl_beat && !len_ok;
      st_frm_err <= abort_beat || bad_beat || stray_beat;
      if (trl_beat) begin
        {st_evt_type, st_trig, st_bx, st_src} <= hdr_q;
        st_len <= sat_len(cnt_nxt);
      end else if (abort_beat || bad_beat) begin
        {st_evt_type, st_trig, st_bx, st_src} <= hdr_q;
        st_len <= sat_len(cnt_q);
      end else begin
        {st_evt_type, st_trig, st_bx, st_src} <= '0;
        st_len <= '0;
      end
    end
  end
endmodule

// File: rtl/fc_checker.sv
module fc_checker (
  input logic clk,
  input logic rst_n,
  input logic beat,
  input logic in_frag,
  input logic in_ctrl,
  input logic pay_beat,
  input logic trl_beat,
  input logic abort_beat,
  input logic st_valid,
  input logic st_crc_err,
  input logic st_len_err,
  input logic st_frm_err
);
  // R1 / R6: a status pulse always follows an accepted word
  assert_status_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(beat));

  // R3: a trailer inside a fragment yields a clean-framed pulse next cycle
  assert_trailer_reports_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trl_beat |=> (st_valid && !st_frm_err));

  // R6: payload words stay silent
  assert_payload_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pay_beat |=> !st_valid);

  // R7: data outside a fragment is a framing fault
  assert_stray_data_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !in_frag && !in_ctrl) |=> (st_valid && st_frm_err));

  // R8: an abort reports framing only, and the fragment stays open
  assert_abort_reports_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_beat |=> (st_valid && st_frm_err && !st_crc_err && !st_len_err && in_frag));

  // R3: pulse is a single cycle unless another word was taken
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !beat) |=> !st_valid);
endmodule

bind frame_checker fc_checker u_fc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .beat       (beat),
  .in_frag    (in_frag),
  .in_ctrl    (in_ctrl),
  .pay_beat   (pay_beat),
  .trl_beat   (trl_beat),
  .abort_beat (abort_beat),
  .st_valid   (st_valid),
  .st_crc_err (st_crc_err),
  .st_len_err (st_len_err),
  .st_frm_err (st_frm_err)
);

// File: tb/tb_frame_checker.sv
module tb_frame_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready = 1'b1, in_ctrl = 1'b0;
  logic [63:0] in_data = '0;
  logic st_valid, st_crc_err, st_len_err, st_frm_err;
  logic [3:0] st_evt_type;
  logic [23:0] st_trig, st_len;
  logic [11:0] st_bx, st_src;

  int nchk = 0, nerr = 0, npulse = 0, exp_pulse = 0;
  logic [15:0] ecrc;
  int ecnt;

  always #10 clk = ~clk;

  frame_checker dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ctrl(in_ctrl), .in_data(in_data), .st_valid(st_valid),
    .st_evt_type(st_evt_type), .st_trig(st_trig), .st_bx(st_bx), .st_src(st_src),
    .st_len(st_len), .st_crc_err(st_crc_err), .st_len_err(st_len_err),
    .st_frm_err(st_frm_err)
  );

  always @(negedge clk) if (rst_n && st_valid) npulse++;

  // Byte-at-a-time CRC-16/0x1021, MSB first, kept separate from the RTL form.
  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [63:0] w);
    logic [15:0] x;
    x = c;
    for (int b = 7; b >= 0; b--) begin
      x = x ^ {w[b*8 +: 8], 8'h00};
      for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    end
    return x;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic ctl, input logic [63:0] w, input logic rdy);
    @(negedge clk);
    in_valid = 1'b1; in_ready = rdy; in_ctrl = ctl; in_data = w;
    @(posedge clk);
    #1 in_valid = 1'b0; in_ready = 1'b1; in_ctrl = 1'b0;
  endtask

  task automatic t_hdr(input logic [3:0] e, input logic [23:0] t, input logic [11:0] b, input logic [11:0] s);
    logic [63:0] w;
    w = {4'h5, e, t, b, s, 4'h1, 4'h0};
    ecrc = bcrc(16'hFFFF, w);
    ecnt = 1;
    put(1'b1, w, 1'b1);
  endtask

  task automatic t_pay(input int n, input int seed, input bit stall);
    logic [63:0] w;
    for (int i = 0; i < n; i++) begin
      if (stall) begin
        put(1'b1, {4'hA, 28'h0, 32'hDEAD0000}, 1'b0); // fake trailer, not accepted (R6)
        @(negedge clk);
      end
      w = {32'(i + seed) * 32'h9E3779B1, 32'(i) ^ 32'h5A5A5A5A};
      ecrc = bcrc(ecrc, w);
      ecnt++;
      put(1'b0, w, 1'b1);
    end
  endtask

  task automatic t_trl(input int ladj, input bit cflip);
    logic [63:0] w;
    logic [23:0] lf;
    lf = 24'(ecnt + 1 + ladj);
    w = {4'hA, 4'h0, lf, 16'h0000, 4'h0, 8'h3C, 4'h0};
    ecrc = bcrc(ecrc, w);
    ecnt++;
    w[31:16] = ecrc ^ {15'd0, cflip};
    put(1'b1, w, 1'b1);
  endtask

  task automatic chk_stat(input string req, input logic [3:0] e, input logic [23:0] t,
                          input logic [11:0] b, input logic [11:0] s, input int len,
                          input bit ce, input bit le, input bit fe);
    @(negedge clk);
    exp_pulse++;
    chk(req, "st_valid", 64'(st_valid), 64'd1);
    chk(req, "hdr fields", {st_evt_type, st_trig, st_bx, st_src}, {e, t, b, s});
    chk(req, "st_len", 64'(st_len), 64'(len));
    chk(req, "err flags", {st_crc_err, st_len_err, st_frm_err}, {ce, le, fe});
  endtask

  localparam int NV = 6;
  localparam int V_NPAY[NV] = '{0, 1, 3, 7, 12, 4};
  localparam int V_LADJ[NV] = '{0, 0, 1, 0, -2, 0};
  localparam bit V_CFLIP[NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam bit V_STALL[NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 chk("R1", "st_valid in reset", 64'(st_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "st_valid idle", 64'(st_valid), 64'd0);

    // R1/R7: a trailer before any header is a framing fault
    put(1'b1, {4'hA, 60'h0}, 1'b1);
    chk_stat("R7", 4'h0, 24'h0, 12'h0, 12'h0, 0, 0, 0, 1);

    // Vector table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      logic [3:0] e; logic [23:0] t; logic [11:0] b, s;
      e = 4'(v + 1); t = 24'h100000 + 24'(v * 7); b = 12'hABC - 12'(v); s = 12'h3F0 + 12'(v);
      t_hdr(e, t, b, s);
      t_pay(V_NPAY[v], v * 13, V_STALL[v]);
      t_trl(V_LADJ[v], V_CFLIP[v]);
      chk_stat("R2 R3 R4 R5 R6", e, t, b, s, V_NPAY[v] + 2, V_CFLIP[v], V_LADJ[v] != 0, 0);
    end

    // R7: stray payload word while hunting
    put(1'b0, 64'h0123456789ABCDEF, 1'b1);
    chk_stat("R7", 4'h0, 24'h0, 12'h0, 12'h0, 0, 0, 0, 1);

    // R8: second header cuts the first fragment, then the new one completes
    t_hdr(4'h7, 24'hAAAA01, 12'h111, 12'h222);
    t_pay(2, 5, 0);
    t_hdr(4'h9, 24'hBBBB02, 12'h333, 12'h444);
    chk_stat("R8", 4'h7, 24'hAAAA01, 12'h111, 12'h222, 3, 0, 0, 1);
    t_pay(1, 9, 0);
    t_trl(0, 0);
    chk_stat("R8", 4'h9, 24'hBBBB02, 12'h333, 12'h444, 3, 0, 0, 0);

    // R9: unknown marker inside a fragment, then data is stray
    t_hdr(4'h2, 24'h00C0DE, 12'h055, 12'h066);
    t_pay(3, 21, 0);
    put(1'b1, {4'h3, 60'h0}, 1'b1);
    chk_stat("R9", 4'h2, 24'h00C0DE, 12'h055, 12'h066, 4, 0, 0, 1);
    put(1'b0, 64'h55, 1'b1);
    chk_stat("R9", 4'h0, 24'h0, 12'h0, 12'h0, 0, 0, 0, 1);

    // R6: offered-only words have no effect; a valid fragment still checks clean
    put(1'b0, 64'h77, 1'b0);
    put(1'b1, {4'h5, 60'h1}, 1'b0);
    @(negedge clk);
    chk("R6", "st_valid after unaccepted words", 64'(st_valid), 64'd0);
    t_hdr(4'hF, 24'hFFFFFF, 12'hFFF, 12'hFFF);
    t_trl(0, 0);
    chk_stat("R6", 4'hF, 24'hFFFFFF, 12'hFFF, 12'hFFF, 2, 0, 0, 0);

    repeat (3) @(negedge clk);
    chk("R3", "pulse count", 64'(npulse), 64'(exp_pulse));
    finish_run();
  end
endmodule